// File: doc/BRIEF.md
# Audio Stream Channel-Order Checker

This block sits in front of an audio serializer and inspects a 32-bit AXI4-Stream of coded audio words. Every word carries a channel number on its 3-bit TID and a 4-bit preamble code in its low nibble. The preamble marks a block start on channel 0, a left (even) channel or a right (odd) channel. Above the preamble sit a 24-bit sample and four status bits.

The checker follows the expected channel, which counts up from 0 and wraps at a configurable channel count. It reports two kinds of fault. An order error means a word did not carry the expected channel. A block-sync error means the preamble does not match the channel. After reset, and after any fault, the checker hunts for a block start on channel 0. It drops every word until that start arrives, then resumes checking. Words that pass are handed downstream on the same cycle, split into sample, status bits, channel and a block-start marker.

Fault flags are sticky until software-independent clear strobe `clr_err` is pulsed. A separate one-cycle pulse marks each fault as it occurs. The stream ready is taken straight from the downstream ready input.

Top module: `aud_seq_checker`

## Requirements
- R1: `s_ready` equals `dn_ready`. A word is accepted only on a cycle where `s_valid` and `s_ready` are both high. A word offered while `dn_ready` is low changes no state, raises no flag and is not delivered.
- R2: After reset the checker is out of sync: `in_sync`=0, `err_order`=0, `err_sync`=0, `err_pulse`=0.
- R3: While out of sync, accepted words are dropped (`o_stb`=0). The exception is a word with preamble 4'b0001 on channel 0: it is delivered, and `in_sync` is 1 from the next cycle.
- R4: A delivered word raises `o_stb` in its acceptance cycle with the following fields: `o_sample`=data[27:4], `o_status`=data[31:28] (parity, channel status, user, validity, from MSB down), `o_chan`=TID, and `o_blk_start` high when the preamble is 4'b0001.
- R5: In sync, the expected channel starts at 1 after a block start and advances by one per delivered word, wrapping from NUM_CH-1 (default 4 channels) to 0. Channel 0 may carry preamble 4'b0001 or 4'b0010.
- R6: In sync, an accepted word whose TID differs from the expected channel is dropped. It sets `err_order` from the next cycle.
- R7: In sync, an accepted word is dropped and sets `err_sync` from the next cycle when any of these holds: preamble 4'b0001 with TID not 0; preamble 4'b0010 with odd TID; preamble 4'b0011 with even TID; any other preamble code.
- R8: Any fault clears `in_sync` from the next cycle. From then on the checker hunts as in R3.
- R9: `err_order` and `err_sync` stay set until a cycle with `clr_err` high, which clears them on the next cycle. A fault in the same cycle as `clr_err` wins, and its flag stays set.
- R10: `err_pulse` is high for exactly the one cycle after each faulting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream ready (follows dn_ready) |
| s_data | input | 32 | Coded audio word |
| s_id | input | 3 | Channel number |
| dn_ready | input | 1 | Downstream ready |
| clr_err | input | 1 | Clear strobe for sticky flags |
| o_stb | output | 1 | Word delivered this cycle |
| o_sample | output | 24 | Sample field |
| o_status | output | 4 | P, C, U, V bits |
| o_chan | output | 3 | Channel number of delivered word |
| o_blk_start | output | 1 | Delivered word starts a block |
| in_sync | output | 1 | Checker is tracking the sequence |
| err_order | output | 1 | Sticky order-error flag |
| err_sync | output | 1 | Sticky block-sync error flag |
| err_pulse | output | 1 | One-cycle fault pulse |

## Verification
Delivery (`o_stb` and the extracted fields) is combinational, so it is due in the acceptance cycle itself. The bench drives each word just after a falling edge and samples delivery a nanosecond later, before the rising edge. `in_sync`, both sticky flags and `err_pulse` each pass through one register, so they are due after the rising edge that accepts the word. The bench samples them one nanosecond after that edge, before the next word is driven. Clear and set-versus-clear cases are sampled the same way, one edge after the strobe.

// File: rtl/aud_seq_pkg.sv
package aud_seq_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned STAT_W   = 4;
  localparam int unsigned PRE_W    = 4;

  localparam logic [PRE_W-1:0] PRE_BLOCK = 4'b0001;
  localparam logic [PRE_W-1:0] PRE_LEFT  = 4'b0010;
  localparam logic [PRE_W-1:0] PRE_RIGHT = 4'b0011;

  typedef struct packed {
    logic [STAT_W-1:0]   status;
    logic [SAMPLE_W-1:0] sample;
    logic [PRE_W-1:0]    pre;
  } aud_word_t;

endpackage

// File: rtl/aud_word_split.sv
module aud_word_split
  import aud_seq_pkg::*;
#(
  parameter int unsigned ID_W = 3
) (
  input  logic [WORD_W-1:0]   word,
  input  logic [ID_W-1:0]     id,
  output logic [SAMPLE_W-1:0] sample,
  output logic [STAT_W-1:0]   status,
  output logic                is_blk,
  output logic                pre_bad
);

  aud_word_t fields;
  logic      odd_id;
  logic      id_zero;

  always_comb begin
    fields  = aud_word_t'(word);
    sample  = fields.sample;
    status  = fields.status;
    odd_id  = id[0];
    id_zero = (id == '0);
    is_blk  = (fields.pre == PRE_BLOCK);
    unique case (fields.pre)
      PRE_BLOCK: pre_bad = !id_zero;
      PRE_LEFT:  pre_bad = odd_id;
      PRE_RIGHT: pre_bad = !odd_id;
      default:   pre_bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/aud_chan_tracker.sv
module aud_chan_tracker #(
  parameter int unsigned ID_W   = 3,
  parameter int unsigned NUM_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            start_seen,
  input  logic            fault,
  output logic            in_sync,
  output logic [ID_W-1:0] exp_ch
);

  localparam int unsigned      FULL_RANGE = 1 << ID_W;
  localparam logic [ID_W-1:0]  LAST_CH    = ID_W'(NUM_CH - 1);
  localparam logic [ID_W-1:0]  ONE_CH     = ID_W'(1);

  logic            sync_q, sync_d;
  logic [ID_W-1:0] exp_q, exp_d;
  logic [ID_W-1:0] exp_inc;
  logic [ID_W-1:0] first_after_start;
  logic            sync_en, exp_en;

  generate
    if (NUM_CH == FULL_RANGE) begin : g_wrap_natural
      assign exp_inc           = exp_q + ONE_CH;
      assign first_after_start = ONE_CH;
    end else begin : g_wrap_cmp
      assign exp_inc           = (exp_q == LAST_CH) ? '0 : exp_q + ONE_CH;
      assign first_after_start = (NUM_CH == 1) ? '0 : ONE_CH;
    end
  endgenerate

  always_comb begin
    sync_d  = sync_q;
    exp_d   = exp_q;
    sync_en = 1'b0;
    exp_en  = 1'b0;
    if (acc) begin
      if (!sync_q) begin
        if (start_seen) begin
          sync_d  = 1'b1;
          exp_d   = first_after_start;
          sync_en = 1'b1;
          exp_en  = 1'b1;
        end
      end else if (fault) begin
        sync_d  = 1'b0;
        sync_en = 1'b1;
      end else begin
        exp_d  = exp_inc;
        exp_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else if (sync_en) begin
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
    end else if (exp_en) begin
      exp_q <= exp_d;
    end
  end

  assign in_sync = sync_q;
  assign exp_ch  = exp_q;

endmodule

// File: rtl/aud_err_flags.sv
module aud_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_order,
  input  logic set_sync,
  input  logic clr,
  output logic err_order,
  output logic err_sync,
  output logic err_pulse
);

  logic ord_q, ord_d;
  logic syn_q, syn_d;
  logic pls_q, pls_d;
  logic ord_en, syn_en;

  always_comb begin
    ord_en = set_order | clr;
    syn_en = set_sync | clr;
    ord_d  = set_order;
    syn_d  = set_sync;
    pls_d  = set_order | set_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q <= 1'b0;
    end else if (ord_en) begin
      ord_q <= ord_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q <= 1'b0;
    end else if (syn_en) begin
      syn_q <= syn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= 1'b0;
    end else begin
      pls_q <= pls_d;
    end
  end

  assign err_order = ord_q;
  assign err_sync  = syn_q;
  assign err_pulse = pls_q;

endmodule

// File: rtl/aud_seq_checker.sv
module aud_seq_checker
  import aud_seq_pkg::*;
#(
  parameter int unsigned ID_W   = 3,
  parameter int unsigned NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [WORD_W-1:0]   s_data,
  input  logic [ID_W-1:0]     s_id,
  input  logic                dn_ready,
  input  logic                clr_err,
  output logic                o_stb,
  output logic [SAMPLE_W-1:0] o_sample,
  output logic [STAT_W-1:0]   o_status,
  output logic [ID_W-1:0]     o_chan,
  output logic                o_blk_start,
  output logic                in_sync,
  output logic                err_order,
  output logic                err_sync,
  output logic                err_pulse
);

  logic            acc;
  logic            is_blk;
  logic            pre_bad;
  logic            start_seen;
  logic            ord_bad;
  logic            syn_bad;
  logic            fault;
  logic            sync_st;
  logic [ID_W-1:0] exp_ch;

  aud_word_split #(.ID_W(ID_W)) u_split (
    .word    (s_data),
    .id      (s_id),
    .sample  (o_sample),
    .status  (o_status),
    .is_blk  (is_blk),
    .pre_bad (pre_bad)
  );

  always_comb begin
    acc        = s_valid & dn_ready;
    start_seen = is_blk & (s_id == '0);
    ord_bad    = acc & sync_st & (s_id != exp_ch);
    syn_bad    = acc & sync_st & pre_bad;
    fault      = ord_bad | syn_bad;
    o_stb      = acc & (sync_st ? !fault : start_seen);
  end

  aud_chan_tracker #(.ID_W(ID_W), .NUM_CH(NUM_CH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .start_seen (start_seen),
    .fault      (fault),
    .in_sync    (sync_st),
    .exp_ch     (exp_ch)
  );

  aud_err_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_order (ord_bad),
    .set_sync  (syn_bad),
    .clr       (clr_err),
    .err_order (err_order),
    .err_sync  (err_sync),
    .err_pulse (err_pulse)
  );

  assign s_ready     = dn_ready;
  assign o_chan      = s_id;
  assign o_blk_start = is_blk;
  assign in_sync     = sync_st;

endmodule

// File: rtl/aud_seq_checker_sva.sv
module aud_seq_checker_sva #(
  parameter int unsigned ID_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s_valid,
  input logic [31:0]     s_data,
  input logic [ID_W-1:0] s_id,
  input logic            dn_ready,
  input logic            clr_err,
  input logic            o_stb,
  input logic [23:0]     o_sample,
  input logic            in_sync,
  input logic            err_order,
  input logic            err_sync,
  input logic            err_pulse
);

  AST_STB_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    o_stb |-> (s_valid && dn_ready)); // R1

  AST_HUNT_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (o_stb && !in_sync) |-> (s_data[3:0] == 4'b0001 && s_id == '0)); // R3

  AST_SAMPLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    o_stb |-> (o_sample == s_data[27:4])); // R4

  AST_FAULT_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !in_sync); // R8

  AST_ORDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_order && !clr_err) |=> err_order); // R9

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sync && !clr_err) |=> err_sync); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse); // R10

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_order || err_sync)); // R10

endmodule

bind aud_seq_checker aud_seq_checker_sva #(.ID_W(ID_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_data    (s_data),
  .s_id      (s_id),
  .dn_ready  (dn_ready),
  .clr_err   (clr_err),
  .o_stb     (o_stb),
  .o_sample  (o_sample),
  .in_sync   (in_sync),
  .err_order (err_order),
  .err_sync  (err_sync),
  .err_pulse (err_pulse)
);

// File: tb/aud_seq_checker_tb.sv
module aud_seq_checker_tb;

  logic        clk;
  logic        rst_n;
  logic        s_valid;
  logic        s_ready;
  logic [31:0] s_data;
  logic [2:0]  s_id;
  logic        dn_ready;
  logic        clr_err;
  logic        o_stb;
  logic [23:0] o_sample;
  logic [3:0]  o_status;
  logic [2:0]  o_chan;
  logic        o_blk_start;
  logic        in_sync;
  logic        err_order;
  logic        err_sync;
  logic        err_pulse;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  aud_seq_checker #(.ID_W(3), .NUM_CH(4)) u_dut (
    .clk, .rst_n, .s_valid, .s_ready, .s_data, .s_id, .dn_ready, .clr_err,
    .o_stb, .o_sample, .o_status, .o_chan, .o_blk_start, .in_sync,
    .err_order, .err_sync, .err_pulse
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic e_sync_st, input logic e_ord,
                       input logic e_syn, input logic e_pls);
    chk(in_sync == e_sync_st, req, "in_sync", in_sync, e_sync_st);
    chk(err_order == e_ord, req, "err_order", err_order, e_ord);
    chk(err_sync == e_syn, req, "err_sync", err_sync, e_syn);
    chk(err_pulse == e_pls, req, "err_pulse", err_pulse, e_pls);
  endtask

  // One word: drive after falling edge, check delivery before rising edge,
  // then leave flags to be checked 1 ns after the rising edge.
  task automatic send(input logic [2:0] id, input logic [3:0] pre,
                      input logic [23:0] smp, input logic [3:0] st,
                      input logic rdy, input logic clr,
                      input logic e_stb, input string req);
    @(negedge clk);
    s_valid  = 1'b1;
    s_id     = id;
    s_data   = {st, smp, pre};
    dn_ready = rdy;
    clr_err  = clr;
    #1;
    chk(s_ready == rdy, "R1", "s_ready", s_ready, rdy);
    chk(o_stb == e_stb, req, "o_stb", o_stb, e_stb);
    if (e_stb) begin
      chk(o_sample == smp, "R4", "o_sample", o_sample, smp);
      chk(o_status == st, "R4", "o_status", o_status, st);
      chk(o_chan == id, "R4", "o_chan", o_chan, id);
      chk(o_blk_start == (pre == 4'b0001), "R4", "o_blk_start", o_blk_start, pre == 4'b0001);
    end
    @(posedge clk);
    #1;
    s_valid  = 1'b0;
    dn_ready = 1'b1;
    clr_err  = 1'b0;
  endtask

  task automatic idle(input logic clr);
    @(negedge clk);
    s_valid = 1'b0;
    clr_err = clr;
    @(posedge clk);
    #1;
    clr_err = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    flags("R2", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hunt;
    send(3'd1, 4'b0011, 24'h111111, 4'h1, 1'b1, 1'b0, 1'b0, "R3");
    flags("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    send(3'd0, 4'b0010, 24'h222222, 4'h2, 1'b1, 1'b0, 1'b0, "R3");
    flags("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    send(3'd0, 4'b0001, 24'hABCDEF, 4'hA, 1'b1, 1'b0, 1'b1, "R3");
    flags("R3", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sequence;
    send(3'd1, 4'b0011, 24'h000001, 4'h5, 1'b1, 1'b0, 1'b1, "R5");
    send(3'd2, 4'b0010, 24'hFFFFFF, 4'hF, 1'b1, 1'b0, 1'b1, "R5");
    send(3'd3, 4'b0011, 24'h800000, 4'h8, 1'b1, 1'b0, 1'b1, "R5");
    send(3'd0, 4'b0010, 24'h123456, 4'h3, 1'b1, 1'b0, 1'b1, "R5");
    flags("R5", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_backpressure;
    // expected channel is 1; a wrong word offered with ready low must be ignored
    send(3'd2, 4'b0011, 24'h0BAD00, 4'h0, 1'b0, 1'b0, 1'b0, "R1");
    flags("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    send(3'd1, 4'b0011, 24'h654321, 4'hC, 1'b1, 1'b0, 1'b1, "R1");
    flags("R1", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_order_err;
    // expected 2, send 3
    send(3'd3, 4'b0011, 24'h333333, 4'h0, 1'b1, 1'b0, 1'b0, "R6");
    flags("R6", 1'b0, 1'b1, 1'b0, 1'b1);
    send(3'd2, 4'b0010, 24'h444444, 4'h0, 1'b1, 1'b0, 1'b0, "R8");
    flags("R10", 1'b0, 1'b1, 1'b0, 1'b0);
    send(3'd0, 4'b0001, 24'h555555, 4'h6, 1'b1, 1'b0, 1'b1, "R8");
    flags("R8", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_clear;
    idle(1'b0);
    flags("R9", 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b1);
    flags("R9", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic resync;
    send(3'd0, 4'b0001, 24'h0F0F0F, 4'h9, 1'b1, 1'b0, 1'b1, "R3");
  endtask

  task automatic t_sync_err;
    // expected 1: right order but left preamble on odd channel
    send(3'd1, 4'b0010, 24'h777777, 4'h0, 1'b1, 1'b0, 1'b0, "R7");
    flags("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    resync();
    // block start on channel 1
    send(3'd1, 4'b0001, 24'h888888, 4'h0, 1'b1, 1'b0, 1'b0, "R7");
    flags("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    resync();
    // unknown preamble code
    send(3'd1, 4'b0111, 24'h999999, 4'h0, 1'b1, 1'b0, 1'b0, "R7");
    flags("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    resync();
    send(3'd1, 4'b0011, 24'hAAAAAA, 4'h0, 1'b1, 1'b0, 1'b1, "R7");
    // expected 2: right preamble on even channel
    send(3'd2, 4'b0011, 24'hBBBBBB, 4'h0, 1'b1, 1'b0, 1'b0, "R7");
    flags("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    flags("R9", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_set_beats_clear;
    resync();
    // expected 1; channel 2 with clear in the same cycle
    send(3'd2, 4'b0010, 24'hCCCCCC, 4'h0, 1'b1, 1'b1, 1'b0, "R9");
    flags("R9", 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n    = 1'b0;
    s_valid  = 1'b0;
    s_data   = '0;
    s_id     = '0;
    dn_ready = 1'b1;
    clr_err  = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    #2;
    rst_n = 1'b1;
    t_hunt();
    t_sequence();
    t_backpressure();
    t_order_err();
    t_clear();
    t_sync_err();
    t_set_beats_clear();
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule